// File: doc/BRIEF.md
# ECC Decode Result Collector

This block gathers the per-sector outcome of an ECC decode across one page. After a start pulse it latches the number of sectors in the page and the correction strength in force. It then waits until the decoder has flagged every active sector as finished. The wait has a bounded time limit. If the limit runs out before all active sectors finish, a timeout flag rises and no results are produced.

Once all active sectors are finished, the block walks through the sectors one per clock. For each sector it takes the error count from a packed set of 32-bit status words and sorts the sector into one of three classes:

- clean (count zero),
- corrected (count reported),
- uncorrectable (count above the strength).

A page-level bad flag summarises the uncorrectable sectors. A one-cycle valid strobe marks the end of the walk. All results stay in place until the next start.

Top module: `ecc_err_collect`

## Requirements
- R1: A start pulse clears `complete`, `result_valid`, `page_bad`, `timeout`, and all per-sector counts and bad bits in the following cycle. It also latches `steps` and `strength`. Results that a run produces stay unchanged until the next start.
- R2: `complete` rises when `done_vec` ANDed with a mask of the lowest `steps` bits equals that mask. `done_vec` bits at or above `steps` have no effect.
- R3: The error count of sector i is the 5-bit field at bit offset 32*(i/4) + 5*(i mod 4) of `status_words`. Bit 0 of that field is the least significant bit of the count.
- R4: When a sector's count is at or below `strength`, that count appears in `sect_cnt[5*i +: 5]` and `sect_bad[i]` is 0.
- R5: When a sector's count is above `strength`, `sect_bad[i]` is 1 and its `sect_cnt` field is 0. `page_bad` is 1 when and only when at least one active sector is bad.
- R6: `result_valid` is high for exactly one cycle. It rises exactly `steps` cycles after `complete` rises, because sectors are classified one per clock.
- R7: If `complete` has not risen `TIMEOUT_CYC` cycles after start, `timeout` rises. After a timeout, `result_valid` and `complete` stay low until the next start.
- R8: A `steps` value above `MAX_STEPS` is treated as `MAX_STEPS`.
- R9: Sectors at index `steps` or above report a count of 0 and a bad bit of 0. A `steps` value of 0 therefore completes at once and reports a clean page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new page collection |
| steps | input | $clog2(MAX_STEPS+1) | Number of sectors in the page (sampled at start) |
| strength | input | 5 | Correctable bits per sector (sampled at start) |
| done_vec | input | MAX_STEPS | Per-sector decoder finished flags |
| status_words | input | 32*ceil(MAX_STEPS/4) | Packed per-sector error counts, four per word |
| complete | output | 1 | All active sectors reported finished |
| result_valid | output | 1 | One-cycle strobe: classification finished |
| sect_cnt | output | 5*MAX_STEPS | Per-sector corrected bit count |
| sect_bad | output | MAX_STEPS | Per-sector uncorrectable flag |
| page_bad | output | 1 | At least one sector is uncorrectable |
| timeout | output | 1 | Finished flags did not arrive in time |

## Verification
The checker watches several properties on every cycle:

- the single-cycle shape of the valid strobe,
- agreement between the page flag and the per-sector bad bits while the strobe is high,
- inactive sectors reading as zero,
- timeout excluding completion,
- the clearing that follows a start.

Other behaviours can only be shown by the bench's scenarios. These are:

- the field layout of the counts in the status words,
- the exact boundary between corrected and uncorrectable counts,
- the cycle distance from completion to the strobe,
- the masking of finished bits above the step count,
- the clamping of an oversize step count,
- the exact cycle on which the timeout fires.

// File: rtl/ecc_collect_pkg.sv
package ecc_collect_pkg;

    localparam int STATUS_W        = 32;
    localparam int CNT_W           = 5;
    localparam int FIELD_STRIDE    = 5;
    localparam int FIELDS_PER_WORD = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SCAN,
        ST_FIN
    } coll_state_e;

    typedef struct packed {
        logic             bad;
        logic [CNT_W-1:0] cnt;
    } sect_res_t;

    // Sort one sector: counts above the strength are uncorrectable and report zero.
    function automatic sect_res_t grade(input logic [CNT_W-1:0] raw,
                                        input logic [CNT_W-1:0] limit);
        sect_res_t r;
        r.bad = (raw > limit);
        r.cnt = r.bad ? '0 : raw;
        return r;
    endfunction

endpackage

// File: rtl/ecc_done_mask.sv
module ecc_done_mask #(
    parameter int MAX_STEPS = 8,
    parameter int STEP_W    = 4
) (
    input  logic [STEP_W-1:0]    steps_q,
    input  logic [MAX_STEPS-1:0] done_vec,
    output logic                 all_done
);

    logic [MAX_STEPS-1:0] active;

    for (genvar g = 0; g < MAX_STEPS; g++) begin : g_mask
        assign active[g] = (STEP_W'(g) < steps_q);
    end

    assign all_done = ((done_vec & active) == active);

endmodule

// File: rtl/ecc_field_sel.sv
module ecc_field_sel
    import ecc_collect_pkg::*;
#(
    parameter int MAX_STEPS = 8,
    parameter int NUM_WORDS = 2,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_WORDS*STATUS_W-1:0] status_words,
    input  logic [IDX_W-1:0]              idx,
    output logic [CNT_W-1:0]              raw_cnt
);

    localparam int USED_W = FIELDS_PER_WORD * FIELD_STRIDE;

    logic [CNT_W-1:0] fields [MAX_STEPS];

    for (genvar g = 0; g < MAX_STEPS; g++) begin : g_field
        localparam int BASE = (g / FIELDS_PER_WORD) * STATUS_W
                            + (g % FIELDS_PER_WORD) * FIELD_STRIDE;
        assign fields[g] = status_words[BASE +: CNT_W];
    end

    // Bits past the last field of each word carry nothing for this block.
    logic [NUM_WORDS-1:0] unused_hi;
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_spare
        assign unused_hi[w] = ^status_words[w*STATUS_W+USED_W +: STATUS_W-USED_W];
    end

    assign raw_cnt = fields[idx];

endmodule

// File: rtl/ecc_sect_regs.sv
module ecc_sect_regs
    import ecc_collect_pkg::*;
#(
    parameter int MAX_STEPS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                       clk,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  sect_res_t                  wr_res,
    output logic [MAX_STEPS*CNT_W-1:0] sect_cnt,
    output logic [MAX_STEPS-1:0]       sect_bad
);

    for (genvar g = 0; g < MAX_STEPS; g++) begin : g_ent
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (clr) begin
                sect_cnt[g*CNT_W +: CNT_W] <= '0;
                sect_bad[g]                <= 1'b0;
            end else if (hit) begin
                sect_cnt[g*CNT_W +: CNT_W] <= wr_res.cnt;
                sect_bad[g]                <= wr_res.bad;
            end
        end
    end

endmodule

// File: rtl/ecc_err_collect.sv
module ecc_err_collect
    import ecc_collect_pkg::*;
#(
    parameter int MAX_STEPS   = 8,
    parameter int TIMEOUT_CYC = 64,
    localparam int STEP_W     = $clog2(MAX_STEPS + 1),
    localparam int NUM_WORDS  = (MAX_STEPS + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD,
    localparam int IDX_W      = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [STEP_W-1:0]             steps,
    input  logic [CNT_W-1:0]              strength,
    input  logic [MAX_STEPS-1:0]          done_vec,
    input  logic [NUM_WORDS*STATUS_W-1:0] status_words,
    output logic                          complete,
    output logic                          result_valid,
    output logic [MAX_STEPS*CNT_W-1:0]    sect_cnt,
    output logic [MAX_STEPS-1:0]          sect_bad,
    output logic                          page_bad,
    output logic                          timeout
);

    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [STEP_W-1:0] STEPS_CAP = STEP_W'(MAX_STEPS);
    localparam logic [TMR_W-1:0]  TMR_LAST  = TMR_W'(TIMEOUT_CYC - 1);

    coll_state_e        state;
    logic [TMR_W-1:0]   timer;
    logic [IDX_W-1:0]   idx;
    logic [STEP_W-1:0]  steps_q;
    logic [CNT_W-1:0]   strength_q;
    logic               all_done;
    logic [CNT_W-1:0]   raw_cnt;
    sect_res_t          cur_res;
    logic               last_sect;

    ecc_done_mask #(
        .MAX_STEPS (MAX_STEPS),
        .STEP_W    (STEP_W)
    ) u_mask (
        .steps_q   (steps_q),
        .done_vec  (done_vec),
        .all_done  (all_done)
    );

    ecc_field_sel #(
        .MAX_STEPS    (MAX_STEPS),
        .NUM_WORDS    (NUM_WORDS),
        .IDX_W        (IDX_W)
    ) u_sel (
        .status_words (status_words),
        .idx          (idx),
        .raw_cnt      (raw_cnt)
    );

    assign cur_res   = grade(raw_cnt, strength_q);
    assign last_sect = (STEP_W'(idx) == (steps_q - STEP_W'(1)));

    ecc_sect_regs #(
        .MAX_STEPS (MAX_STEPS),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk       (clk),
        .clr       (rst || start),
        .wr_en     ((state == ST_SCAN) && !start),
        .wr_idx    (idx),
        .wr_res    (cur_res),
        .sect_cnt  (sect_cnt),
        .sect_bad  (sect_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            timer      <= '0;
            idx        <= '0;
            steps_q    <= '0;
            strength_q <= '0;
            complete   <= 1'b0;
            page_bad   <= 1'b0;
            timeout    <= 1'b0;
        end else if (start) begin
            state      <= ST_WAIT;
            timer      <= '0;
            idx        <= '0;
            steps_q    <= (steps > STEPS_CAP) ? STEPS_CAP : steps;
            strength_q <= strength;
            complete   <= 1'b0;
            page_bad   <= 1'b0;
            timeout    <= 1'b0;
        end else begin
            unique case (state)
                ST_WAIT: begin
                    if (all_done) begin
                        complete <= 1'b1;
                        idx      <= '0;
                        state    <= (steps_q == '0) ? ST_FIN : ST_SCAN;
                    end else if (timer == TMR_LAST) begin
                        timeout  <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        timer    <= timer + TMR_W'(1);
                    end
                end
                ST_SCAN: begin
                    if (cur_res.bad) page_bad <= 1'b1;
                    if (last_sect) state <= ST_FIN;
                    else           idx   <= idx + IDX_W'(1);
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign result_valid = (state == ST_FIN);

endmodule

// File: rtl/ecc_err_collect_chk.sv
module ecc_err_collect_chk
    import ecc_collect_pkg::*;
#(
    parameter int MAX_STEPS = 8,
    parameter int STEP_W    = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       start,
    input logic [STEP_W-1:0]          steps_q,
    input logic                       complete,
    input logic                       result_valid,
    input logic [MAX_STEPS*CNT_W-1:0] sect_cnt,
    input logic [MAX_STEPS-1:0]       sect_bad,
    input logic                       page_bad,
    input logic                       timeout
);

    // R1
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (!page_bad && !timeout && !complete && sect_bad == '0));

    // R5
    page_flag_match_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (page_bad == (|sect_bad)));

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R6
    strobe_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> complete);

    // R7
    timeout_excl_chk: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (!result_valid && !complete));

    for (genvar g = 0; g < MAX_STEPS; g++) begin : g_idle
        // R9
        idle_sector_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (result_valid && (STEP_W'(g) >= steps_q)) |->
                (!sect_bad[g] && sect_cnt[g*CNT_W +: CNT_W] == '0));
        // R5
        bad_cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (result_valid && sect_bad[g]) |-> (sect_cnt[g*CNT_W +: CNT_W] == '0));
    end

endmodule

bind ecc_err_collect ecc_err_collect_chk #(
    .MAX_STEPS    (MAX_STEPS),
    .STEP_W       (STEP_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .steps_q      (steps_q),
    .complete     (complete),
    .result_valid (result_valid),
    .sect_cnt     (sect_cnt),
    .sect_bad     (sect_bad),
    .page_bad     (page_bad),
    .timeout      (timeout)
);

// File: tb/ecc_err_collect_tb.sv
`timescale 1ns/1ps
module ecc_err_collect_tb;

    localparam int MS  = 8;
    localparam int TMO = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  steps_i = '0;
    logic [4:0]  strength_i = '0;
    logic [7:0]  done_i = '0;
    logic [63:0] words_i = '0;
    logic        complete, result_valid, page_bad, timeout;
    logic [39:0] sect_cnt;
    logic [7:0]  sect_bad;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    ecc_err_collect #(.MAX_STEPS(MS), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst(rst), .start(start), .steps(steps_i),
        .strength(strength_i), .done_vec(done_i), .status_words(words_i),
        .complete(complete), .result_valid(result_valid), .sect_cnt(sect_cnt),
        .sect_bad(sect_bad), .page_bad(page_bad), .timeout(timeout)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [4:0] a, b, c, d, e, f, g, h);
        return {12'h0, h, g, f, e, 12'h0, d, c, b, a};
    endfunction

    typedef struct packed {
        logic [3:0]  st;
        logic [4:0]  sr;
        logic [63:0] w;
        logic [7:0]  dv;
        logic [7:0]  lag;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{4'd8,  5'd4,  mk(0,1,2,3,4,5,0,31),       8'hFF, 8'd0},
        '{4'd5,  5'd12, mk(12,13,0,7,9,31,31,31),   8'h1F, 8'd3},
        '{4'd3,  5'd0,  mk(0,1,0,20,20,20,20,20),   8'h07, 8'd0},
        '{4'd8,  5'd31, mk(31,31,31,31,31,31,31,31), 8'hFF, 8'd5},
        '{4'd12, 5'd8,  mk(8,0,0,0,0,0,0,9),        8'hFF, 8'd1},
        '{4'd0,  5'd4,  mk(31,31,31,31,31,31,31,31), 8'h00, 8'd0},
        '{4'd4,  5'd6,  mk(6,0,2,7,1,1,1,1),        8'h0F, 8'd2}
    };

    task automatic do_run(input vec_t v);
        int n;
        int eff;
        bit any_bad;
        logic [4:0] raw, ecnt;
        bit ebad;
        logic [7:0] bad_snap;
        logic [39:0] cnt_snap;
        eff = (v.st > 4'd8) ? 8 : int'(v.st);
        @(negedge clk);
        steps_i = v.st; strength_i = v.sr; words_i = v.w; done_i = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!page_bad && sect_bad == 0 && sect_cnt == 0 && !timeout && !complete,
            "R1 cleared after start", {page_bad, sect_bad}, 0);
        if (v.lag != 0) begin
            repeat (int'(v.lag)) @(negedge clk);
            if (eff != 0) chk(!complete, "R2 no complete before done", complete, 0);
        end
        done_i = v.dv;
        n = 0;
        while (!complete && n < 300) begin @(negedge clk); n++; end
        chk(complete, "R2 complete rises", complete, 1);
        n = 0;
        while (!result_valid && n < 20) begin @(negedge clk); n++; end
        chk(n == eff, "R6 strobe distance (R8 clamp)", n, eff);
        any_bad = 0;
        for (int i = 0; i < MS; i++) begin
            raw = v.w[(i/4)*32 + (i%4)*5 +: 5];
            if (i >= eff) begin ecnt = 0; ebad = 0; end
            else if (raw > v.sr) begin ecnt = 0; ebad = 1; end
            else begin ecnt = raw; ebad = 0; end
            any_bad |= ebad;
            chk(sect_cnt[i*5 +: 5] == ecnt, "R3 R4 R9 sector count", sect_cnt[i*5 +: 5], ecnt);
            chk(sect_bad[i] == ebad, "R5 R9 sector bad", sect_bad[i], ebad);
        end
        chk(page_bad == any_bad, "R5 page flag", page_bad, any_bad);
        bad_snap = sect_bad; cnt_snap = sect_cnt;
        @(negedge clk);
        chk(!result_valid, "R6 strobe one cycle", result_valid, 0);
        repeat (4) @(negedge clk);
        chk(page_bad == any_bad && sect_bad == bad_snap && sect_cnt == cnt_snap,
            "R1 results held", {page_bad, sect_bad}, {any_bad, bad_snap});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!complete && !result_valid && !page_bad && !timeout && sect_bad == 0 && sect_cnt == 0,
            "R1 reset state", {complete, result_valid, page_bad, timeout}, 0);

        for (int k = 0; k < NV; k++) do_run(VEC[k]);

        // R7 with R2: only bits outside the missing sector set, so no completion
        @(negedge clk);
        steps_i = 4'd4; strength_i = 5'd4; words_i = '0; done_i = 8'hF7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (TMO - 1) @(negedge clk);
        chk(!timeout && !complete, "R7 no timeout one cycle early", timeout, 0);
        @(negedge clk);
        chk(timeout, "R7 timeout fires", timeout, 1);
        chk(!complete, "R2 upper done bits ignored", complete, 0);
        repeat (5) @(negedge clk);
        chk(timeout && !result_valid && !complete, "R7 timeout held, no strobe",
            {timeout, result_valid}, 2'b10);

        // R2: bits above steps alone do not complete; once low bits arrive it does
        @(negedge clk);
        steps_i = 4'd2; strength_i = 5'd3; words_i = mk(3,4,0,0,0,0,0,0); done_i = 8'hFC; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!timeout, "R1 start clears timeout", timeout, 0);
        repeat (6) @(negedge clk);
        chk(!complete, "R2 upper bits only", complete, 0);
        done_i = 8'h03;
        @(negedge clk);
        chk(complete, "R2 low bits complete", complete, 1);
        @(negedge clk);
        @(negedge clk);
        chk(result_valid && sect_bad == 8'h02 && sect_cnt[4:0] == 5'd3 && page_bad,
            "R4 R5 boundary", {sect_bad, sect_cnt[4:0]}, {8'h02, 5'd3});

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule